// File: doc/BRIEF.md
# Slot Error Isolation Gate

This block sits between a host-side bus port and a single downstream adapter slot. It passes host reads and writes through to the slot while the slot is healthy. It watches for parity errors on the address and data paths, and for device-initiated DMA that targets an address outside the window assigned to the device. When either kind of error is seen, the block freezes the slot instead of stopping the host. A frozen slot still completes every host read, with data of all ones, and it accepts host writes and then drops them. It grants no DMA while frozen.

The freeze state is kept by a three-state machine:

- `ST_RUN`: MMIO and DMA are both active.
- `ST_FROZEN`: MMIO and DMA are both gated.
- `ST_MMIO_THAWED`: MMIO is active again so that diagnostic reads can be made, but DMA stays gated.

The transitions are:

- `RUN->FROZEN` on any error.
- `FROZEN->MMIO_THAWED` on a thaw command.
- `MMIO_THAWED->FROZEN` on a parity error.
- `any->RUN` on the clear command, which stands for the explicit clear or a slot reset.

All other inputs leave the state unchanged. A one-cycle event pulse marks each entry into the frozen condition from `ST_RUN`.

Host reads that arrive while MMIO is gated are counted modulo a threshold. A warning pulse is raised each time the count wraps, which flags a driver that keeps polling a dead slot. The DMA window is held in a base register and a limit register, and the check against them is inclusive.

Top module: `slot_freeze_gate`

## Requirements
- R1: After reset the state is `ST_RUN`. `mmio_active`, `dma_active` and `healthy` are 1, `freeze_evt` and `rd_warn` are 0, `frz_rd_cnt` is 0, and both window registers hold 0.
- R2: While `mmio_active` is 0, a host read does not reach the slot (`dev_rd_req`=0) and returns `host_rdata` with every bit set. A host write is dropped (`dev_wr_req`=0) and raises no error. While `mmio_active` is 1, requests and read data pass through unchanged.
- R3: In `ST_RUN`, an address parity error or a data parity error, including one that arrives together with a write, freezes the slot. From the next cycle both `mmio_active` and `dma_active` are 0.
- R4: A DMA request is granted only in `ST_RUN` and only when `win_base <= dma_addr <= win_limit`, with both ends included. In `ST_RUN`, a request outside the window is refused in the same cycle and freezes the slot from the next cycle. While DMA is gated, requests are refused and freeze nothing further.
- R5: `mmio_active` and `dma_active` report the gating, and `healthy` is 1 only when both are 1.
- R6: `thaw_mmio` in `ST_FROZEN` moves to `ST_MMIO_THAWED` on the next cycle: `mmio_active`=1 and `dma_active`=0.
- R7: Every host read accepted while `mmio_active` is 0 increments `frz_rd_cnt`. When the count reaches RD_THRESH, it returns to 0 and `rd_warn` pulses for one cycle. Reads while MMIO is active are not counted.
- R8: The frozen condition is sticky and only `clear_frz` returns the block to `ST_RUN`. The clear also zeroes `frz_rd_cnt`, and it wins over an error in the same cycle.
- R9: `freeze_evt` pulses for exactly one cycle, in the first cycle of a freeze from `ST_RUN`. Errors while already frozen or thawed raise no further pulse.
- R10: A parity error in `ST_MMIO_THAWED` returns to `ST_FROZEN` without an event. `thaw_mmio` outside `ST_FROZEN` has no effect.
- R11: `win_wr` loads `win_base_in` and `win_limit_in` into the window registers on the clock edge. The new window applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rd_req | input | 1 | Host read request |
| host_wr_req | input | 1 | Host write request |
| host_addr | input | AW | Host address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Read data to host (all ones when gated) |
| dev_rd_req | output | 1 | Read request to slot |
| dev_wr_req | output | 1 | Write request to slot |
| dev_addr | output | AW | Address to slot |
| dev_wdata | output | DW | Write data to slot |
| dev_rdata | input | DW | Read data from slot |
| addr_par_err | input | 1 | Address parity error |
| data_par_err | input | 1 | Data parity error |
| dma_req | input | 1 | Device DMA request |
| dma_addr | input | AW | Device DMA target address |
| dma_grant | output | 1 | DMA request allowed |
| win_wr | input | 1 | Load the window registers |
| win_base_in | input | AW | New window base |
| win_limit_in | input | AW | New window limit |
| thaw_mmio | input | 1 | Re-enable MMIO only |
| clear_frz | input | 1 | Clear freeze / slot reset |
| mmio_active | output | 1 | MMIO traffic enabled |
| dma_active | output | 1 | DMA traffic enabled |
| healthy | output | 1 | Both MMIO and DMA active |
| freeze_evt | output | 1 | One-cycle pulse per freeze |
| rd_warn | output | 1 | Pulse when frozen-read count wraps |
| frz_rd_cnt | output | CW | Frozen reads since the last wrap |

## Verification
The checker tests the following on every cycle:

- While MMIO is gated, reads return all ones and writes never reach the slot.
- Any parity error or out-of-window DMA in `ST_RUN` freezes the slot on the next cycle.
- The freeze persists until a clear, and a clear restores both status bits and a zero count.
- A thaw opens MMIO but not DMA.
- An event pulse lasts a single cycle and only leaves `ST_RUN`.

Only the bench scenarios show the rest:

- The counter wraps after exactly the threshold number of frozen reads.
- The window edges are inclusive: grant at base and limit, freeze at base-1 and limit+1.
- A clear wins over a simultaneous error.
- Repeated errors while frozen or thawed raise no second event.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
    typedef enum logic [1:0] {
        ST_RUN         = 2'd0,
        ST_FROZEN      = 2'd1,
        ST_MMIO_THAWED = 2'd2
    } sfg_state_e;
endpackage

// File: rtl/sfg_window.sv
module sfg_window #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_wr,
    input  logic [AW-1:0] base_in,
    input  logic [AW-1:0] limit_in,
    input  logic [AW-1:0] addr,
    output logic          in_win
);
    logic [AW-1:0] base_q;
    logic [AW-1:0] limit_q;

    // R11: window registers, loaded on the edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
        end else if (win_wr) begin
            base_q  <= base_in;
            limit_q <= limit_in;
        end
    end

    // R4: inclusive range check, combinational on each request
    assign in_win = (addr >= base_q) && (addr <= limit_q);
endmodule

// File: rtl/sfg_fsm.sv
module sfg_fsm
    import sfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       par_err,
    input  logic       dma_viol,
    input  logic       thaw,
    input  logic       clear,
    output sfg_state_e state,
    output logic       mmio_on,
    output logic       dma_on,
    output logic       freeze_evt
);
    sfg_state_e state_q;
    sfg_state_e state_d;
    logic       evt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // next state (R3, R4, R6, R8, R10)
    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_RUN:         if (par_err || dma_viol) state_d = ST_FROZEN;
                ST_FROZEN:      if (thaw)                state_d = ST_MMIO_THAWED;
                ST_MMIO_THAWED: if (par_err)             state_d = ST_FROZEN;
                default:                                 state_d = ST_FROZEN;
            endcase
        end
    end

    // outputs decoded from the state (R5)
    always_comb begin
        mmio_on = 1'b0;
        dma_on  = 1'b0;
        unique case (state_q)
            ST_RUN:         begin mmio_on = 1'b1; dma_on = 1'b1; end
            ST_FROZEN:      begin mmio_on = 1'b0; dma_on = 1'b0; end
            ST_MMIO_THAWED: begin mmio_on = 1'b1; dma_on = 1'b0; end
            default:        begin mmio_on = 1'b0; dma_on = 1'b0; end
        endcase
    end

    // R9: single event pulse on leaving ST_RUN
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= !clear && (state_q == ST_RUN) && (par_err || dma_viol);
    end

    assign state      = state_q;
    assign freeze_evt = evt_q;
endmodule

// File: rtl/sfg_rdcount.sv
module sfg_rdcount #(
    parameter int RD_THRESH = 2100000,
    parameter int CW        = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          clr,
    output logic [CW-1:0] cnt,
    output logic          warn
);
    localparam logic [CW-1:0] LAST = CW'(RD_THRESH - 1);

    logic [CW-1:0] cnt_q;
    logic          warn_q;

    // R7 / R8: modulo counter of gated reads, cleared with the freeze
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            warn_q <= 1'b0;
        end else if (clr) begin
            cnt_q  <= '0;
            warn_q <= 1'b0;
        end else begin
            warn_q <= inc && (cnt_q == LAST);
            if (inc) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign cnt  = cnt_q;
    assign warn = warn_q;
endmodule

// File: rtl/slot_freeze_gate.sv
module slot_freeze_gate
    import sfg_pkg::*;
#(
    parameter  int AW        = 32,
    parameter  int DW        = 32,
    parameter  int RD_THRESH = 2100000,
    localparam int CW        = $clog2(RD_THRESH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_rd_req,
    input  logic          host_wr_req,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          dev_rd_req,
    output logic          dev_wr_req,
    output logic [AW-1:0] dev_addr,
    output logic [DW-1:0] dev_wdata,
    input  logic [DW-1:0] dev_rdata,
    input  logic          addr_par_err,
    input  logic          data_par_err,
    input  logic          dma_req,
    input  logic [AW-1:0] dma_addr,
    output logic          dma_grant,
    input  logic          win_wr,
    input  logic [AW-1:0] win_base_in,
    input  logic [AW-1:0] win_limit_in,
    input  logic          thaw_mmio,
    input  logic          clear_frz,
    output logic          mmio_active,
    output logic          dma_active,
    output logic          healthy,
    output logic          freeze_evt,
    output logic          rd_warn,
    output logic [CW-1:0] frz_rd_cnt
);
    logic       in_win;
    logic       mmio_on;
    logic       dma_on;
    sfg_state_e state;

    sfg_window #(.AW(AW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_wr   (win_wr),
        .base_in  (win_base_in),
        .limit_in (win_limit_in),
        .addr     (dma_addr),
        .in_win   (in_win)
    );

    sfg_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .par_err    (addr_par_err || data_par_err),
        .dma_viol   (dma_req && !in_win),
        .thaw       (thaw_mmio),
        .clear      (clear_frz),
        .state      (state),
        .mmio_on    (mmio_on),
        .dma_on     (dma_on),
        .freeze_evt (freeze_evt)
    );

    sfg_rdcount #(.RD_THRESH(RD_THRESH), .CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (host_rd_req && (state == ST_FROZEN)),
        .clr   (clear_frz),
        .cnt   (frz_rd_cnt),
        .warn  (rd_warn)
    );

    // R2: gating of host traffic
    assign dev_rd_req  = host_rd_req && mmio_on;
    assign dev_wr_req  = host_wr_req && mmio_on;
    assign dev_addr    = host_addr;
    assign dev_wdata   = host_wdata;
    assign host_rdata  = mmio_on ? dev_rdata : {DW{1'b1}};

    // R4: DMA only in run state and inside the window
    assign dma_grant   = dma_req && dma_on && in_win;

    // R5: status
    assign mmio_active = mmio_on;
    assign dma_active  = dma_on;
    assign healthy     = mmio_on && dma_on;
endmodule

// File: rtl/sfg_checker.sv
module sfg_checker #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 22
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_rd_req,
    input logic          host_wr_req,
    input logic [DW-1:0] host_rdata,
    input logic          dev_rd_req,
    input logic          dev_wr_req,
    input logic          addr_par_err,
    input logic          data_par_err,
    input logic          dma_req,
    input logic          dma_grant,
    input logic          thaw_mmio,
    input logic          clear_frz,
    input logic          mmio_active,
    input logic          dma_active,
    input logic          freeze_evt,
    input logic          rd_warn,
    input logic [CW-1:0] frz_rd_cnt
);
    p_gated_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mmio_active && host_rd_req) |-> (host_rdata == {DW{1'b1}} && !dev_rd_req));

    p_gated_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mmio_active && host_wr_req) |-> !dev_wr_req);

    p_parity_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr_par_err || data_par_err) && dma_active && !clear_frz) |=> (!mmio_active && !dma_active));

    p_grant_only_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_grant |-> (dma_req && dma_active));

    p_refused_dma_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_active && !dma_grant && !clear_frz) |=> !dma_active);

    p_thaw_mmio_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mmio_active && thaw_mmio && !clear_frz) |=> (mmio_active && !dma_active));

    p_warn_wraps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_warn |-> (frz_rd_cnt == '0));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_active && !clear_frz) |=> !dma_active);

    p_clear_restores_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_frz |=> (mmio_active && dma_active && frz_rd_cnt == '0));

    p_evt_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_evt |=> !freeze_evt);

    p_evt_from_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_evt |-> (!dma_active && !mmio_active && $past(dma_active)));
endmodule

bind slot_freeze_gate sfg_checker #(.AW(AW), .DW(DW), .CW(CW)) u_sfg_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_rd_req  (host_rd_req),
    .host_wr_req  (host_wr_req),
    .host_rdata   (host_rdata),
    .dev_rd_req   (dev_rd_req),
    .dev_wr_req   (dev_wr_req),
    .addr_par_err (addr_par_err),
    .data_par_err (data_par_err),
    .dma_req      (dma_req),
    .dma_grant    (dma_grant),
    .thaw_mmio    (thaw_mmio),
    .clear_frz    (clear_frz),
    .mmio_active  (mmio_active),
    .dma_active   (dma_active),
    .freeze_evt   (freeze_evt),
    .rd_warn      (rd_warn),
    .frz_rd_cnt   (frz_rd_cnt)
);

// File: tb/tb_slot_freeze_gate.sv
module tb_slot_freeze_gate;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int THR = 5;
    localparam int CW  = $clog2(THR + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_rd_req = 0, host_wr_req = 0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          dev_rd_req, dev_wr_req;
    logic [AW-1:0] dev_addr;
    logic [DW-1:0] dev_wdata;
    logic [DW-1:0] dev_rdata = 32'h1234_5678;
    logic          addr_par_err = 0, data_par_err = 0;
    logic          dma_req = 0;
    logic [AW-1:0] dma_addr = '0;
    logic          dma_grant;
    logic          win_wr = 0;
    logic [AW-1:0] win_base_in = '0, win_limit_in = '0;
    logic          thaw_mmio = 0, clear_frz = 0;
    logic          mmio_active, dma_active, healthy, freeze_evt, rd_warn;
    logic [CW-1:0] frz_rd_cnt;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    bit run_cmp = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    slot_freeze_gate #(.AW(AW), .DW(DW), .RD_THRESH(THR)) dut (.*);

    // behavioural reference: 0 run, 1 frozen, 2 mmio thawed
    int          m_st;
    int          m_cnt;
    bit          m_evt, m_warn;
    logic [AW-1:0] m_base, m_limit;

    function automatic bit m_inwin();
        return (dma_addr >= m_base) && (dma_addr <= m_limit);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_evt = 0; m_warn = 0; m_base = '0; m_limit = '0;
        end else begin
            bit par, viol;
            int nst;
            par  = addr_par_err || data_par_err;
            viol = dma_req && !m_inwin();
            if (clear_frz) begin
                m_evt = 0; m_warn = 0; m_cnt = 0; nst = 0;
            end else begin
                m_evt  = (m_st == 0) && (par || viol);
                m_warn = (m_st == 1) && host_rd_req && (m_cnt == THR - 1);
                if (m_st == 1 && host_rd_req) m_cnt = (m_cnt == THR - 1) ? 0 : m_cnt + 1;
                nst = m_st;
                if (m_st == 0 && (par || viol)) nst = 1;
                else if (m_st == 1 && thaw_mmio) nst = 2;
                else if (m_st == 2 && par) nst = 1;
            end
            m_st = nst;
            if (win_wr) begin m_base = win_base_in; m_limit = win_limit_in; end
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison with the reference
    always @(negedge clk) begin
        if (run_cmp && rst_n) begin
            bit mm, dd;
            mm = (m_st != 1);
            dd = (m_st == 0);
            chk("R5", "mmio_active", mmio_active, mm);
            chk("R5", "dma_active", dma_active, dd);
            chk("R5", "healthy", healthy, mm && dd);
            chk("R9", "freeze_evt", freeze_evt, m_evt);
            chk("R7", "rd_warn", rd_warn, m_warn);
            chk("R7", "frz_rd_cnt", frz_rd_cnt, m_cnt);
            chk("R2", "dev_rd_req", dev_rd_req, host_rd_req && mm);
            chk("R2", "dev_wr_req", dev_wr_req, host_wr_req && mm);
            chk("R2", "host_rdata", host_rdata, mm ? dev_rdata : {DW{1'b1}});
            chk("R4", "dma_grant", dma_grant, dma_req && dd && m_inwin());
        end
    end

    task automatic idle();
        host_rd_req = 0; host_wr_req = 0; addr_par_err = 0; data_par_err = 0;
        dma_req = 0; win_wr = 0; thaw_mmio = 0; clear_frz = 0;
    endtask

    // inputs applied now are sampled at the next posedge; returns at negedge+1
    task automatic step();
        @(negedge clk); #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk("R1", "mmio_active", mmio_active, 1);
        chk("R1", "dma_active", dma_active, 1);
        chk("R1", "healthy", healthy, 1);
        chk("R1", "freeze_evt", freeze_evt, 0);
        chk("R1", "frz_rd_cnt", frz_rd_cnt, 0);
        rst_n = 1;
        run_cmp = 1;
        step();

        // R11: load the window 0x1000..0x1FFF
        win_wr = 1; win_base_in = 32'h1000; win_limit_in = 32'h1FFF;
        step(); idle();
        // R4: both window edges granted
        dma_req = 1; dma_addr = 32'h1000; #1;
        chk("R4", "grant at base", dma_grant, 1);
        chk("R11", "window loaded", dma_grant, 1);
        step();
        dma_addr = 32'h1FFF; #1;
        chk("R4", "grant at limit", dma_grant, 1);
        step(); idle();

        // R2: pass-through while healthy
        host_rd_req = 1; dev_rdata = 32'hCAFE_0001; step();
        chk("R2", "pass rdata", host_rdata, 32'hCAFE_0001);
        host_rd_req = 0; host_wr_req = 1; host_wdata = 32'h55; step();
        chk("R2", "pass write", dev_wr_req, 1);
        idle();

        // R4: DMA at limit+1 -> refused, freeze
        dma_req = 1; dma_addr = 32'h2000; #1;
        chk("R4", "refuse limit+1", dma_grant, 0);
        step(); idle();
        chk("R9", "event pulse", freeze_evt, 1);
        chk("R4", "frozen after oow", dma_active, 0);
        step();
        chk("R9", "pulse one cycle", freeze_evt, 0);

        // R7: twelve frozen reads, with some writes
        for (int i = 0; i < 12; i++) begin
            host_rd_req = 1; host_wr_req = (i % 3 == 0); step();
            chk("R2", "gated rdata", host_rdata, 32'hFFFF_FFFF);
            chk("R2", "gated write", dev_wr_req, 0);
            if (i == 4 || i == 9) chk("R7", "warn on wrap", rd_warn, 1);
        end
        idle();
        chk("R7", "count after 12", frz_rd_cnt, 2);

        // R9: parity while frozen -> no second event
        addr_par_err = 1; step(); idle();
        chk("R9", "no second event", freeze_evt, 0);

        // R6: thaw MMIO only
        thaw_mmio = 1; step(); idle();
        chk("R6", "mmio thawed", mmio_active, 1);
        chk("R6", "dma still off", dma_active, 0);
        host_rd_req = 1; dev_rdata = 32'hABCD_0000; step();
        chk("R7", "thawed read not counted", frz_rd_cnt, 2);
        chk("R6", "thawed rdata", host_rdata, 32'hABCD_0000);
        host_rd_req = 0; dma_req = 1; dma_addr = 32'h1800; #1;
        chk("R4", "no dma when thawed", dma_grant, 0);
        step(); idle();
        chk("R4", "blocked dma no event", freeze_evt, 0);

        // R10: thaw ignored while thawed, parity refreezes without event
        thaw_mmio = 1; step(); idle();
        chk("R10", "thaw in thawed", dma_active, 0);
        data_par_err = 1; step(); idle();
        chk("R10", "refrozen", mmio_active, 0);
        chk("R10", "no event on refreeze", freeze_evt, 0);

        // R8: sticky, then clear wins over error
        repeat (3) step();
        chk("R8", "still frozen", mmio_active, 0);
        clear_frz = 1; addr_par_err = 1; step(); idle();
        chk("R8", "cleared", healthy, 1);
        chk("R8", "count zeroed", frz_rd_cnt, 0);
        chk("R8", "no event on clear", freeze_evt, 0);

        // R10: thaw in run has no effect
        thaw_mmio = 1; step(); idle();
        chk("R10", "thaw in run", healthy, 1);

        // R3: data parity during a posted write
        host_wr_req = 1; data_par_err = 1; step(); idle();
        chk("R3", "write parity freezes", mmio_active, 0);
        chk("R9", "event on parity", freeze_evt, 1);
        clear_frz = 1; step(); idle();

        // R3: address parity
        addr_par_err = 1; step(); idle();
        chk("R3", "addr parity freezes", dma_active, 0);
        clear_frz = 1; step(); idle();

        // R4: base-1 refused and freezes
        dma_req = 1; dma_addr = 32'h0FFF; #1;
        chk("R4", "refuse base-1", dma_grant, 0);
        step(); idle();
        chk("R4", "freeze on base-1", dma_active, 0);
        clear_frz = 1; step(); idle();
        step();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule